// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two control strobes of a multiplexed external bus: an address-latch pulse (active high) and a program-read strobe (active low). It runs from the oscillator clock and divides it into a machine cycle of twelve phases, split into two halves of six. Each half opens with an address-latch window and follows it with a program-read window, so that one instruction byte can be fetched per half cycle.

The block also decides, once per half cycle, whether the current fetch address lies in on-chip program memory or must go out on the bus. A strap input, captured while reset is held, either allows on-chip memory up to a boundary chosen by a size code, or forces every fetch onto the bus. When a machine cycle carries an external data access, the block drops the second address-latch pulse and both program-read pulses of that cycle. A quiet-bus control keeps the address latch idle except in those data cycles.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst` is high, `ale` is 1, `psen_n` is 1 and `fetch_ext` is 0. The first clock edge after `rst` falls emits phase 0 of a new machine cycle.
- R2: A machine cycle is 12 clocks, numbered 0 to 11. In an ordinary cycle (`xdata_req` 0, `ale_off` 0), `ale` is high in phases 0, 1, 6 and 7 and low otherwise. This gives two pulses, each two clocks wide, per cycle: one sixth of the clock rate.
- R3: In an ordinary cycle whose fetch is external, `psen_n` is low in phases 2, 3, 4 and 8, 9, 10 and high otherwise.
- R4: `psen_n` never goes low during a half cycle in which `fetch_ext` is 0.
- R5: With the captured strap at 1, `fetch_ext` is 1 exactly when `pc` exceeds the boundary chosen by `rom_size`: code 0 gives 0FFFh, 1 gives 1FFFh, 2 gives 3FFFh and 3 gives 7FFFh. `pc` is sampled on the edges that emit phases 0 and 6, and the result holds for that half cycle.
- R6: With the captured strap at 0, `fetch_ext` is 1 for every `pc`.
- R7: `rom_strap` is captured on every clock while `rst` is high. Changes to it after reset is released do not affect `fetch_ext`.
- R8: `xdata_req` is sampled on the edge that emits phase 0 and marks that whole machine cycle as a data cycle. In a data cycle, `ale` is high only in phases 0 and 1, and `psen_n` stays high throughout.
- R9: With `ale_off` at 1, `ale` stays low for a whole ordinary cycle and is high only in phases 0 and 1 of a data cycle. `psen_n` behaves as it does with `ale_off` at 0.
- R10: `ale` high and `psen_n` low never occur in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; one phase per cycle |
| rst | input | 1 | Synchronous reset, active high |
| rom_strap | input | 1 | Strap: 1 allows on-chip program memory, 0 forces all fetches external; captured during reset |
| pc | input | 16 | Fetch address |
| rom_size | input | 2 | On-chip memory size code (0: 4K, 1: 8K, 2: 16K, 3: 32K) |
| ale_off | input | 1 | Quiet-bus control: address latch only in data cycles |
| xdata_req | input | 1 | The machine cycle starting now carries an external data access |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-read strobe, active low |
| fetch_ext | output | 1 | Current half-cycle fetch goes to external memory |

## Verification
The assertions assume that reset is held for at least one clock before strobe activity is judged. They also assume that `xdata_req`, `ale_off`, `pc` and `rom_size` only change at machine-cycle boundaries, so no window is cut short by a mid-cycle change. The stimulus sets every input on a falling edge just before the edge that emits phase 0, holds it for all twelve phases, and moves the strap only while reset is high, except in the scenarios that show a late strap change is ignored.

// File: rtl/bsg_pkg.sv
`timescale 1ns/1ps
package bsg_pkg;

    // On-chip program memory size codes; each step doubles the boundary.
    typedef enum logic [1:0] {
        ROM_4K  = 2'd0,
        ROM_8K  = 2'd1,
        ROM_16K = 2'd2,
        ROM_32K = 2'd3
    } rom_size_e;

    // Position of a phase within its half cycle.
    function automatic int half_offset(input int phase, input int half);
        return (phase >= half) ? phase - half : phase;
    endfunction

endpackage

// File: rtl/bsg_phase.sv
`timescale 1ns/1ps
module bsg_phase #(
    parameter int PHASES = 12,
    parameter int CW     = $clog2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xdata_req,
    output logic [CW-1:0] phase,
    output logic          half_start,
    output logic          data_now
);
    localparam int          HALF = PHASES / 2;
    localparam logic [CW-1:0] LAST = CW'(PHASES - 1);
    localparam logic [CW-1:0] MID  = CW'(HALF);

    typedef struct packed {
        logic [CW-1:0] cnt;   // phase emitted on the next edge
        logic          xd;    // current machine cycle is a data cycle
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        if (st_q.cnt == '0) begin
            st_d.xd = xdata_req;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase      = st_q.cnt;
    assign half_start = (st_q.cnt == '0) || (st_q.cnt == MID);
    assign data_now   = (st_q.cnt == '0) ? xdata_req : st_q.xd;

endmodule

// File: rtl/bsg_fetch_sel.sv
`timescale 1ns/1ps
module bsg_fetch_sel #(
    parameter int PC_W      = 16,
    parameter int BASE_LOG2 = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rom_strap,
    input  logic [PC_W-1:0] pc,
    input  logic [1:0]      rom_size,
    input  logic            half_start,
    output logic            fetch_now,
    output logic            fetch_ext
);
    typedef struct packed {
        logic ea;    // strap captured during reset
        logic ext;   // fetch decision of the current half cycle
    } st_t;

    st_t          st_d, st_q;
    logic [PC_W:0] span;
    logic          ext_dec;

    always_comb begin
        span    = (PC_W+1)'(1) << (BASE_LOG2 + int'(rom_size));
        ext_dec = !st_q.ea || ({1'b0, pc} >= span);
    end

    always_comb begin
        st_d = st_q;
        if (half_start) begin
            st_d.ext = ext_dec;
        end
        if (rst) begin
            st_d.ea  = rom_strap;
            st_d.ext = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fetch_now = half_start ? ext_dec : st_q.ext;
    assign fetch_ext = st_q.ext;

endmodule

// File: rtl/bsg_strobe.sv
`timescale 1ns/1ps
module bsg_strobe #(
    parameter int PHASES = 12,
    parameter int CW     = $clog2(PHASES),
    parameter int ALE_W  = 2,
    parameter int PSEN_W = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] phase,
    input  logic          data_now,
    input  logic          fetch_now,
    input  logic          ale_off,
    output logic          ale,
    output logic          psen_n
);
    import bsg_pkg::*;

    localparam int HALF = PHASES / 2;

    typedef struct packed {
        logic ale;
        logic psen_n;
    } st_t;

    st_t  st_d, st_q;
    int   off;
    logic first_half, in_ale, in_psen;

    always_comb begin
        off        = half_offset(int'(phase), HALF);
        first_half = int'(phase) < HALF;
        in_ale     = off < ALE_W;
        in_psen    = (off >= ALE_W) && (off < ALE_W + PSEN_W);
    end

    always_comb begin
        st_d = st_q;
        if (first_half) begin
            st_d.ale = in_ale && (ale_off ? data_now : 1'b1);
        end else begin
            st_d.ale = in_ale && !data_now && !ale_off;
        end
        st_d.psen_n = !(in_psen && !data_now && fetch_now);
        if (rst) begin
            st_d.ale    = 1'b1;
            st_d.psen_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ale    = st_q.ale;
    assign psen_n = st_q.psen_n;

endmodule

// File: rtl/bus_strobe_gen.sv
`timescale 1ns/1ps
module bus_strobe_gen #(
    parameter int PHASES    = 12,
    parameter int PC_W      = 16,
    parameter int BASE_LOG2 = 12,
    parameter int ALE_W     = 2,
    parameter int PSEN_W    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rom_strap,
    input  logic [PC_W-1:0] pc,
    input  logic [1:0]      rom_size,
    input  logic            ale_off,
    input  logic            xdata_req,
    output logic            ale,
    output logic            psen_n,
    output logic            fetch_ext
);
    localparam int CW = $clog2(PHASES);

    logic [CW-1:0] phase;
    logic          half_start;
    logic          data_now;
    logic          fetch_now;

    bsg_phase #(.PHASES(PHASES), .CW(CW)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .xdata_req  (xdata_req),
        .phase      (phase),
        .half_start (half_start),
        .data_now   (data_now)
    );

    bsg_fetch_sel #(.PC_W(PC_W), .BASE_LOG2(BASE_LOG2)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .rom_strap  (rom_strap),
        .pc         (pc),
        .rom_size   (rom_size),
        .half_start (half_start),
        .fetch_now  (fetch_now),
        .fetch_ext  (fetch_ext)
    );

    bsg_strobe #(.PHASES(PHASES), .CW(CW), .ALE_W(ALE_W), .PSEN_W(PSEN_W)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .data_now   (data_now),
        .fetch_now  (fetch_now),
        .ale_off    (ale_off),
        .ale        (ale),
        .psen_n     (psen_n)
    );

endmodule

// File: rtl/bsg_checker.sv
`timescale 1ns/1ps
module bsg_checker (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic psen_n,
    input logic fetch_ext
);
    // R10: the two strobes are never active in the same clock
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(ale && !psen_n));

    // R2: an address-latch pulse lasts exactly two clocks
    assert_ale_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ale) |=> ale ##1 !ale);

    // R3: a program-read pulse lasts exactly three clocks
    assert_psen_width_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(psen_n) |=> !psen_n ##1 !psen_n ##1 psen_n);

    // R4: program reads only while the fetch is external
    assert_psen_ext_only_R4: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> fetch_ext);
endmodule

bind bus_strobe_gen bsg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ale       (ale),
    .psen_n    (psen_n),
    .fetch_ext (fetch_ext)
);

// File: tb/bus_strobe_gen_test.sv
`timescale 1ns/1ps
module bus_strobe_gen_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rom_strap = 1'b1;
    logic [15:0] pc = '0;
    logic [1:0]  rom_size = '0;
    logic        ale_off = 1'b0;
    logic        xdata_req = 1'b0;
    logic        ale, psen_n, fetch_ext;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bus_strobe_gen uut (
        .clk(clk), .rst(rst), .rom_strap(rom_strap), .pc(pc),
        .rom_size(rom_size), .ale_off(ale_off), .xdata_req(xdata_req),
        .ale(ale), .psen_n(psen_n), .fetch_ext(fetch_ext)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reset with a given strap; checks the reset state (R1).
    task automatic do_reset(input bit strap);
        rst = 1'b1;
        rom_strap = strap;
        repeat (3) @(negedge clk);
        check(ale == 1'b1, "R1", "ale in reset", int'(ale), 1);
        check(psen_n == 1'b1, "R1", "psen_n in reset", int'(psen_n), 1);
        check(fetch_ext == 1'b0, "R1", "fetch_ext in reset", int'(fetch_ext), 0);
        rst = 1'b0;
    endtask

    // One machine cycle; called at a falling edge just before phase 0.
    task automatic run_mc(input bit dx, input bit aoff, input logic [15:0] pcv,
                          input logic [1:0] sz, input bit ea_lat, input string req);
        int  limit;
        bit  fext, e_ale, e_psen_n;
        xdata_req = dx;
        ale_off   = aoff;
        pc        = pcv;
        rom_size  = sz;
        limit = (32'h1000 << sz) - 1;
        fext  = !ea_lat || (int'(pcv) > limit);
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            if (p < 2)
                e_ale = aoff ? dx : 1'b1;
            else if (p == 6 || p == 7)
                e_ale = !dx && !aoff;
            else
                e_ale = 1'b0;
            e_psen_n = !((((p >= 2) && (p <= 4)) || ((p >= 8) && (p <= 10))) && !dx && fext);
            check(ale == e_ale, req, $sformatf("ale phase %0d", p), int'(ale), int'(e_ale));
            check(psen_n == e_psen_n, req, $sformatf("psen_n phase %0d", p),
                  int'(psen_n), int'(e_psen_n));
            check(fetch_ext == fext, req, $sformatf("fetch_ext phase %0d", p),
                  int'(fetch_ext), int'(fext));
        end
    endtask

    task automatic t_normal();
        do_reset(1'b1);
        run_mc(1'b0, 1'b0, 16'h0000, 2'd0, 1'b1, "R1_R2");
        run_mc(1'b0, 1'b0, 16'h1234, 2'd0, 1'b1, "R3");
        run_mc(1'b0, 1'b0, 16'h0800, 2'd0, 1'b1, "R4");
        run_mc(1'b0, 1'b0, 16'hFFFF, 2'd3, 1'b1, "R3");
    endtask

    task automatic t_bounds();
        do_reset(1'b1);
        for (int s = 0; s < 4; s++) begin
            logic [15:0] lim;
            lim = 16'((32'h1000 << s) - 1);
            run_mc(1'b0, 1'b0, lim, 2'(s), 1'b1, "R5");
            run_mc(1'b0, 1'b0, lim + 16'd1, 2'(s), 1'b1, "R5");
        end
    endtask

    task automatic t_strap();
        do_reset(1'b1);
        rom_strap = 1'b0;   // late change must be ignored
        run_mc(1'b0, 1'b0, 16'h0010, 2'd0, 1'b1, "R7");
        do_reset(1'b0);
        run_mc(1'b0, 1'b0, 16'h0000, 2'd3, 1'b0, "R6");
        run_mc(1'b0, 1'b0, 16'h0100, 2'd1, 1'b0, "R6");
        rom_strap = 1'b1;
        run_mc(1'b0, 1'b0, 16'h0020, 2'd0, 1'b0, "R7");
    endtask

    task automatic t_data();
        do_reset(1'b1);
        run_mc(1'b0, 1'b0, 16'h2000, 2'd0, 1'b1, "R3");
        run_mc(1'b1, 1'b0, 16'h2000, 2'd0, 1'b1, "R8");
        run_mc(1'b0, 1'b0, 16'h2001, 2'd0, 1'b1, "R8");
        run_mc(1'b1, 1'b0, 16'h0004, 2'd0, 1'b1, "R8");
    endtask

    task automatic t_ale_off();
        do_reset(1'b1);
        run_mc(1'b0, 1'b1, 16'h9000, 2'd1, 1'b1, "R9");
        run_mc(1'b1, 1'b1, 16'h9000, 2'd1, 1'b1, "R9");
        run_mc(1'b0, 1'b1, 16'h0002, 2'd1, 1'b1, "R9");
        run_mc(1'b0, 1'b0, 16'h9000, 2'd1, 1'b1, "R10");
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_normal();
        t_bounds();
        t_strap();
        t_data();
        t_ale_off();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule